// File: doc/BRIEF.md
# USB OTG Host Role Swap Controller

This block runs the role exchange that lets a dual-role USB port lend its host function to the attached partner and then take it back. A single parameter builds it either as the side that owns the host role after a session starts (the A side) or as the side that starts as a peripheral and may borrow the host role (the B side). It works only on simple level and event inputs. These are a 1 ms tick, a full-speed flag, a flag saying that host negotiation was enabled by the A side, an idle detector, and one-cycle connect and disconnect events. It drives a host-enable level, a D+ pull-up enable, a one-cycle bus-reset request and a one-cycle resume request.

On the B side, software asks for the host role while the link is idle. The controller then drops the pull-up, which looks like a disconnect. When the A side answers by connecting as a device, the B side takes the host role and asks for a bus reset. On the A side, a qualifying disconnect is answered in one of two ways, chosen by a handover-allowed input. Either the A side steps down and connects as a peripheral, or it keeps the host role and asks for resume signalling. After stepping down, the A side counts idle milliseconds to see the end of the borrowed session. It then drops its pull-up, and when the partner connects again it resumes as host with a bus reset. If the expected connect does not arrive in time, either side returns to its original role and raises an error flag.

Top module: `otg_role_swap`

## Requirements
- R1: After reset the A-side build has host_en=1 and the B-side build has dp_pullup=1. All other outputs are 0.
- R2: host_en and dp_pullup are never 1 in the same cycle.
- R3: Negotiation starts only while full_speed=1 and hnp_enabled=1. While either is 0, disconnect events on the A side and host requests on the B side have no effect. The B side also requires bus_idle=1 to start.
- R4: In the A-side build, a qualifying disc_evt with handover_ok=1 gives host_en=0 and dp_pullup=1 from the next cycle.
- R5: In the A-side build, a qualifying disc_evt with handover_ok=0 gives a one-cycle resume_req in the next cycle, and host_en stays 1. The B-side build never asserts resume_req.
- R6: While the A side is a peripheral, it counts tick_1ms pulses that arrive with bus_idle=1, and any cycle with bus_idle=0 clears the count. The cycle after the count reaches IDLE_MS (default 3), dp_pullup falls to 0 and host_en stays 0.
- R7: While the A side waits with both outputs low, a conn_evt gives host_en=1 and bus_reset=1 in the next cycle.
- R8: In the B-side build, a qualifying want_host drops dp_pullup in the next cycle.
- R9: While the B side waits with its pull-up removed, a conn_evt gives host_en=1 and bus_reset=1 in the next cycle.
- R10: While the B side waits, a cycle with bus_idle=0 (the partner kept the host role and resumed) returns it to dp_pullup=1 in the next cycle, with no error.
- R11: While the B side is host, host_done returns it to host_en=0 and dp_pullup=1 in the next cycle.
- R12: If no conn_evt arrives within CONN_TMO_MS ticks of waiting (default 8), the side returns to its original role and neg_error becomes 1. The flag stays set until the next negotiation starts, which clears it.
- R13: bus_reset is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| full_speed | input | 1 | Link is operating at full speed |
| hnp_enabled | input | 1 | Host negotiation has been enabled by the A side |
| bus_idle | input | 1 | Bus shows no activity in this cycle |
| conn_evt | input | 1 | One-cycle pulse: partner connect seen |
| disc_evt | input | 1 | One-cycle pulse: partner disconnect seen (A side) |
| handover_ok | input | 1 | A side: give up the host role (1) or resume (0) |
| want_host | input | 1 | B side: request the host role |
| host_done | input | 1 | B side: finished as host |
| host_en | output | 1 | Host function enabled |
| dp_pullup | output | 1 | D+ pull-up enabled (acting as peripheral) |
| bus_reset | output | 1 | One-cycle bus-reset request |
| resume_req | output | 1 | One-cycle resume-signalling request |
| neg_error | output | 1 | Last negotiation timed out |

## Verification
The bench builds both the A-side and the B-side variants and drives them with the same stimulus. A reference model checks every output of each variant in every cycle. The stimulus targets these corner cases:
- Disconnects and requests that arrive while full-speed or negotiation enable is missing. A design that ignores this gating would hand over the host role illegally.
- An idle gap one tick short of the limit, broken by activity. A counter that does not clear would drop the pull-up too early.
- A partner that answers with resume instead of a connect. A B side that misses this would hang until the timeout and raise a false error.
- Connect timeouts on both sides, followed by a fresh negotiation. A design that does not clear the flag, or that returns to the wrong role, shows a mismatch on neg_error, host_en or dp_pullup.

// File: rtl/otg_swap_pkg.sv
package otg_swap_pkg;
   typedef enum logic [1:0] {
      AS_HOST   = 2'd0,
      AS_PERIPH = 2'd1,
      AS_WAIT   = 2'd2
   } a_state_t;

   typedef enum logic [1:0] {
      BS_PERIPH = 2'd0,
      BS_REQ    = 2'd1,
      BS_HOST   = 2'd2
   } b_state_t;
endpackage

// File: rtl/otg_ms_window.sv
// Saturating millisecond counter: counts ticks while run is high, clears when run is low.
module otg_ms_window #(
   parameter int LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   output logic reached
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (!run)                  cnt_q <= '0;
      else if (tick && cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
   end

   assign reached = (cnt_q == LIM_C);
endmodule

// File: rtl/otg_a_side.sv
module otg_a_side #(
   parameter int IDLE_MS     = 3,
   parameter int CONN_TMO_MS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1ms,
   input  logic full_speed,
   input  logic hnp_enabled,
   input  logic bus_idle,
   input  logic conn_evt,
   input  logic disc_evt,
   input  logic handover_ok,
   output logic host_en,
   output logic dp_pullup,
   output logic bus_reset,
   output logic resume_req,
   output logic neg_error
);
   import otg_swap_pkg::*;

   a_state_t st_q, st_d;
   logic rst_q, rst_d, res_q, res_d, err_q, err_d;
   logic idle_hit, tmo_hit;

   otg_ms_window #(.LIMIT(IDLE_MS)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1ms),
      .run     (st_q == AS_PERIPH && bus_idle),
      .reached (idle_hit)
   );

   otg_ms_window #(.LIMIT(CONN_TMO_MS)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1ms),
      .run     (st_q == AS_WAIT),
      .reached (tmo_hit)
   );

   always_comb begin
      st_d  = st_q;
      rst_d = 1'b0;
      res_d = 1'b0;
      err_d = err_q;
      unique case (st_q)
         AS_HOST: begin
            if (disc_evt && full_speed && hnp_enabled) begin
               if (handover_ok) begin
                  st_d  = AS_PERIPH;
                  err_d = 1'b0;
               end else begin
                  res_d = 1'b1;
               end
            end
         end
         AS_PERIPH: begin
            if (idle_hit) st_d = AS_WAIT;
         end
         AS_WAIT: begin
            if (conn_evt) begin
               st_d  = AS_HOST;
               rst_d = 1'b1;
            end else if (tmo_hit) begin
               st_d  = AS_HOST;
               err_d = 1'b1;
            end
         end
         default: st_d = AS_HOST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= AS_HOST;
         rst_q <= 1'b0;
         res_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         rst_q <= rst_d;
         res_q <= res_d;
         err_q <= err_d;
      end
   end

   assign host_en    = (st_q == AS_HOST);
   assign dp_pullup  = (st_q == AS_PERIPH);
   assign bus_reset  = rst_q;
   assign resume_req = res_q;
   assign neg_error  = err_q;
endmodule

// File: rtl/otg_b_side.sv
module otg_b_side #(
   parameter int CONN_TMO_MS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1ms,
   input  logic full_speed,
   input  logic hnp_enabled,
   input  logic bus_idle,
   input  logic conn_evt,
   input  logic want_host,
   input  logic host_done,
   output logic host_en,
   output logic dp_pullup,
   output logic bus_reset,
   output logic neg_error
);
   import otg_swap_pkg::*;

   b_state_t st_q, st_d;
   logic rst_q, rst_d, err_q, err_d;
   logic tmo_hit;

   otg_ms_window #(.LIMIT(CONN_TMO_MS)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1ms),
      .run     (st_q == BS_REQ),
      .reached (tmo_hit)
   );

   always_comb begin
      st_d  = st_q;
      rst_d = 1'b0;
      err_d = err_q;
      unique case (st_q)
         BS_PERIPH: begin
            if (want_host && full_speed && hnp_enabled && bus_idle) begin
               st_d  = BS_REQ;
               err_d = 1'b0;
            end
         end
         BS_REQ: begin
            if (conn_evt) begin
               st_d  = BS_HOST;
               rst_d = 1'b1;
            end else if (!bus_idle) begin
               st_d = BS_PERIPH;
            end else if (tmo_hit) begin
               st_d  = BS_PERIPH;
               err_d = 1'b1;
            end
         end
         BS_HOST: begin
            if (host_done) st_d = BS_PERIPH;
         end
         default: st_d = BS_PERIPH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= BS_PERIPH;
         rst_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         rst_q <= rst_d;
         err_q <= err_d;
      end
   end

   assign host_en   = (st_q == BS_HOST);
   assign dp_pullup = (st_q == BS_PERIPH);
   assign bus_reset = rst_q;
   assign neg_error = err_q;
endmodule

// File: rtl/otg_role_swap.sv
module otg_role_swap #(
   parameter bit A_SIDE      = 1'b1,
   parameter int IDLE_MS     = 3,
   parameter int CONN_TMO_MS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1ms,
   input  logic full_speed,
   input  logic hnp_enabled,
   input  logic bus_idle,
   input  logic conn_evt,
   input  logic disc_evt,
   input  logic handover_ok,
   input  logic want_host,
   input  logic host_done,
   output logic host_en,
   output logic dp_pullup,
   output logic bus_reset,
   output logic resume_req,
   output logic neg_error
);
   if (IDLE_MS < 1) begin : g_bad_idle
      $error("otg_role_swap: IDLE_MS must be at least 1");
   end
   if (CONN_TMO_MS < 1) begin : g_bad_tmo
      $error("otg_role_swap: CONN_TMO_MS must be at least 1");
   end

   if (A_SIDE) begin : g_a
      logic unused_b;
      assign unused_b = &{1'b0, want_host, host_done};
      otg_a_side #(.IDLE_MS(IDLE_MS), .CONN_TMO_MS(CONN_TMO_MS)) u_side (
         .clk         (clk),
         .rst_n       (rst_n),
         .tick_1ms    (tick_1ms),
         .full_speed  (full_speed),
         .hnp_enabled (hnp_enabled),
         .bus_idle    (bus_idle),
         .conn_evt    (conn_evt),
         .disc_evt    (disc_evt),
         .handover_ok (handover_ok),
         .host_en     (host_en),
         .dp_pullup   (dp_pullup),
         .bus_reset   (bus_reset),
         .resume_req  (resume_req),
         .neg_error   (neg_error)
      );
   end else begin : g_b
      logic unused_a;
      assign unused_a = &{1'b0, disc_evt, handover_ok};
      assign resume_req = 1'b0;
      otg_b_side #(.CONN_TMO_MS(CONN_TMO_MS)) u_side (
         .clk         (clk),
         .rst_n       (rst_n),
         .tick_1ms    (tick_1ms),
         .full_speed  (full_speed),
         .hnp_enabled (hnp_enabled),
         .bus_idle    (bus_idle),
         .conn_evt    (conn_evt),
         .want_host   (want_host),
         .host_done   (host_done),
         .host_en     (host_en),
         .dp_pullup   (dp_pullup),
         .bus_reset   (bus_reset),
         .neg_error   (neg_error)
      );
   end
endmodule

// File: rtl/otg_role_swap_chk.sv
module otg_role_swap_chk #(
   parameter bit A_SIDE = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic full_speed,
   input logic hnp_enabled,
   input logic bus_idle,
   input logic disc_evt,
   input logic handover_ok,
   input logic want_host,
   input logic host_en,
   input logic dp_pullup,
   input logic bus_reset,
   input logic resume_req,
   input logic neg_error
);
   // R2
   no_role_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_en && dp_pullup));

   // R13
   reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !bus_reset);

   // R7 R9
   reset_as_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |-> host_en);

   // R12
   error_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(neg_error) |-> (A_SIDE ? host_en : dp_pullup));

   if (A_SIDE) begin : g_a
      // R3
      handover_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(host_en) |-> $past(disc_evt && full_speed && hnp_enabled && handover_ok));
      // R5
      resume_as_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
         resume_req |-> host_en);
   end else begin : g_b
      // R3
      request_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(dp_pullup) |-> $past(want_host && full_speed && hnp_enabled && bus_idle));
      // R5
      no_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !resume_req);
   end
endmodule

bind otg_role_swap otg_role_swap_chk #(.A_SIDE(A_SIDE)) u_chk (.*);

// File: tb/tb_otg_role_swap.sv
`timescale 1ns/1ps
module tb_otg_role_swap;
   localparam int IDLE = 3;
   localparam int TMO  = 8;
   localparam int TDIV = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic tick = 1'b0, full_speed = 1'b0, hnp_enabled = 1'b0, bus_idle = 1'b0;
   logic conn_evt = 1'b0, disc_evt = 1'b0, handover_ok = 1'b0;
   logic want_host = 1'b0, host_done = 1'b0;
   logic a_host, a_pu, a_rst, a_res, a_err;
   logic b_host, b_pu, b_rst, b_res, b_err;

   int checks = 0, fails = 0;
   string phase = "R1";

   otg_role_swap #(.A_SIDE(1'b1), .IDLE_MS(IDLE), .CONN_TMO_MS(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .full_speed(full_speed),
      .hnp_enabled(hnp_enabled), .bus_idle(bus_idle), .conn_evt(conn_evt),
      .disc_evt(disc_evt), .handover_ok(handover_ok), .want_host(want_host),
      .host_done(host_done), .host_en(a_host), .dp_pullup(a_pu),
      .bus_reset(a_rst), .resume_req(a_res), .neg_error(a_err));

   otg_role_swap #(.A_SIDE(1'b0), .IDLE_MS(IDLE), .CONN_TMO_MS(TMO)) dut_b (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .full_speed(full_speed),
      .hnp_enabled(hnp_enabled), .bus_idle(bus_idle), .conn_evt(conn_evt),
      .disc_evt(disc_evt), .handover_ok(handover_ok), .want_host(want_host),
      .host_done(host_done), .host_en(b_host), .dp_pullup(b_pu),
      .bus_reset(b_rst), .resume_req(b_res), .neg_error(b_err));

   // millisecond tick every TDIV cycles
   int tdiv = 0;
   always @(negedge clk) begin
      tick = (tdiv == 0);
      tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
   end

   // behavioural reference: role 0 host / 1 lent-out / 2 waiting (A); 0 device / 1 asking / 2 host (B)
   int am = 0, ai = 0, at = 0, bm = 0, bt = 0, nam, nbm;
   bit ea_rst = 0, ea_res = 0, ea_err = 0, eb_rst = 0, eb_err = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         am = 0; ai = 0; at = 0; bm = 0; bt = 0;
         ea_rst = 0; ea_res = 0; ea_err = 0; eb_rst = 0; eb_err = 0;
      end else begin
         nam = am; ea_rst = 0; ea_res = 0;
         if (am == 0 && disc_evt && full_speed && hnp_enabled) begin
            if (handover_ok) begin nam = 1; ea_err = 0; end
            else ea_res = 1;
         end else if (am == 1 && ai == IDLE) nam = 2;
         else if (am == 2) begin
            if (conn_evt) begin nam = 0; ea_rst = 1; end
            else if (at == TMO) begin nam = 0; ea_err = 1; end
         end
         if (am == 1 && bus_idle) begin if (tick && ai < IDLE) ai++; end else ai = 0;
         if (am == 2) begin if (tick && at < TMO) at++; end else at = 0;
         am = nam;

         nbm = bm; eb_rst = 0;
         if (bm == 0 && want_host && full_speed && hnp_enabled && bus_idle) begin
            nbm = 1; eb_err = 0;
         end else if (bm == 1) begin
            if (conn_evt) begin nbm = 2; eb_rst = 1; end
            else if (!bus_idle) nbm = 0;
            else if (bt == TMO) begin nbm = 0; eb_err = 1; end
         end else if (bm == 2 && host_done) nbm = 0;
         if (bm == 1) begin if (tick && bt < TMO) bt++; end else bt = 0;
         bm = nbm;
      end
   end

   task automatic cmp(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cmp(phase, "A host_en",   a_host, am == 0);
         cmp(phase, "A dp_pullup", a_pu,   am == 1);
         cmp(phase, "A bus_reset", a_rst,  ea_rst);
         cmp(phase, "A resume",    a_res,  ea_res);
         cmp(phase, "A error",     a_err,  ea_err);
         cmp(phase, "B host_en",   b_host, bm == 2);
         cmp(phase, "B dp_pullup", b_pu,   bm == 0);
         cmp(phase, "B bus_reset", b_rst,  eb_rst);
         cmp(phase, "B resume",    b_res,  1'b0);
         cmp(phase, "B error",     b_err,  eb_err);
         cmp("R2", "A role clash", a_host & a_pu, 1'b0);
         cmp("R2", "B role clash", b_host & b_pu, 1'b0);
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp("R1", "A host_en", a_host, 1'b1);  cmp("R1", "A dp_pullup", a_pu, 1'b0);
      cmp("R1", "A bus_reset", a_rst, 1'b0); cmp("R1", "A error", a_err, 1'b0);
      cmp("R1", "B dp_pullup", b_pu, 1'b1);  cmp("R1", "B host_en", b_host, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // gating: low speed, then negotiation disabled
      phase = "R3";
      full_speed = 0; hnp_enabled = 1; bus_idle = 1; handover_ok = 1; want_host = 1;
      disc_evt = 1; @(negedge clk); disc_evt = 0;
      repeat (4) @(negedge clk);
      cmp("R3", "A host_en kept", a_host, 1'b1); cmp("R3", "B pull-up kept", b_pu, 1'b1);
      full_speed = 1; hnp_enabled = 0;
      disc_evt = 1; @(negedge clk); disc_evt = 0;
      repeat (4) @(negedge clk);
      cmp("R3", "A host_en kept", a_host, 1'b1); cmp("R3", "B pull-up kept", b_pu, 1'b1);
      want_host = 0; hnp_enabled = 1; bus_idle = 0;
      @(negedge clk);

      // A refuses and resumes
      phase = "R5"; handover_ok = 0;
      disc_evt = 1; @(negedge clk); disc_evt = 0;
      cmp("R5", "A resume pulse", a_res, 1'b1); cmp("R5", "A host_en", a_host, 1'b1);
      @(negedge clk);

      // B asks, partner resumes instead
      phase = "R8"; bus_idle = 1; want_host = 1; @(negedge clk); want_host = 0;
      cmp("R8", "B pull-up dropped", b_pu, 1'b0);
      phase = "R10"; bus_idle = 0; @(negedge clk);
      cmp("R10", "B back to device", b_pu, 1'b1); cmp("R10", "B error", b_err, 1'b0);

      // A hands over
      phase = "R4"; handover_ok = 1;
      disc_evt = 1; @(negedge clk); disc_evt = 0;
      cmp("R4", "A host_en", a_host, 1'b0); cmp("R4", "A dp_pullup", a_pu, 1'b1);

      // B takes host
      phase = "R9"; bus_idle = 1; want_host = 1; @(negedge clk); want_host = 0;
      conn_evt = 1; @(negedge clk); conn_evt = 0;
      cmp("R9", "B bus_reset", b_rst, 1'b1); cmp("R9", "B host_en", b_host, 1'b1);
      bus_idle = 0;

      // idle shorter than the limit is cleared by activity
      phase = "R6";
      repeat (20) @(negedge clk);
      bus_idle = 1; repeat (2 * TDIV) @(negedge clk);
      bus_idle = 0; @(negedge clk);
      cmp("R6", "A pull-up held", a_pu, 1'b1);
      repeat (10) @(negedge clk);

      phase = "R11"; host_done = 1; @(negedge clk); host_done = 0;
      cmp("R11", "B host_en", b_host, 1'b0); cmp("R11", "B dp_pullup", b_pu, 1'b1);

      phase = "R6"; bus_idle = 1;
      repeat (IDLE * TDIV + TDIV + 3) @(negedge clk);
      cmp("R6", "A pull-up removed", a_pu, 1'b0); cmp("R6", "A host_en", a_host, 1'b0);

      phase = "R7"; conn_evt = 1; @(negedge clk); conn_evt = 0;
      cmp("R7", "A host_en", a_host, 1'b1); cmp("R7", "A bus_reset", a_rst, 1'b1);
      phase = "R13"; @(negedge clk);
      cmp("R13", "A bus_reset single", a_rst, 1'b0);

      // timeouts on both sides
      phase = "R12";
      disc_evt = 1; @(negedge clk); disc_evt = 0;
      repeat ((IDLE + TMO + 3) * TDIV) @(negedge clk);
      cmp("R12", "A error", a_err, 1'b1); cmp("R12", "A host_en", a_host, 1'b1);
      want_host = 1; @(negedge clk); want_host = 0;
      repeat ((TMO + 2) * TDIV) @(negedge clk);
      cmp("R12", "B error", b_err, 1'b1); cmp("R12", "B dp_pullup", b_pu, 1'b1);
      want_host = 1; @(negedge clk); want_host = 0;
      cmp("R12", "B error cleared", b_err, 1'b0);
      conn_evt = 1; @(negedge clk); conn_evt = 0;
      cmp("R9", "B host_en", b_host, 1'b1);
      phase = "R13"; @(negedge clk);
      cmp("R13", "B bus_reset single", b_rst, 1'b0);
      host_done = 1; @(negedge clk); host_done = 0;
      repeat (5) @(negedge clk);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule